// File: doc/BRIEF.md
# Queued Word-Aligned DMA Command Engine

This block moves data between memory regions on behalf of software. Software loads a source address, a destination address and two lengths counted in 32-bit words into registers. It then writes the destination length, and that write places a complete command in a four-deep command queue. The engine takes the command at the head of the queue. It works through that command in chunks of at most 256 words over a simple request/acknowledge memory port that carries one word per handshake.

The engine has two modes, chosen by a software-visible loopback bit. With loopback off, it only reads and consumes the source words. With loopback on, it reads a whole chunk into a local buffer and then writes that chunk to the destination in the same order. When a command is finished, the engine raises two completion flags in a write-1-to-clear interrupt status register and removes the command from the queue. A mask register selects which status flags drive the single interrupt line. A read-only queue status word reports whether the queue is full or empty.

Top module: `dma_cmd_engine`

## Requirements
- R1: After reset, the interrupt status (index 4) reads 0x8802_0000, the mask (index 5) reads 0xFFFF_FFFF, the queue status (index 6) reads 0x4000_0000, the mode register (index 7) reads 0 and irq is low.
- R2: Register indices are 0 source address, 1 destination address, 2 source length and 3 destination length. A write to index 3 enqueues a command made from the current indices 0 to 2 and the written value. Both addresses have bits 1:0 cleared when the command is captured.
- R3: The length registers keep only bits 26:0 of a write. Bits 31:27 read as zero.
- R4: With loopback off, a command reads its source words one after another, starting at the aligned source address and adding 4 per word. It performs no writes, and it completes once the source length is used up, whatever the destination length is.
- R5: With loopback on, each chunk is the smallest of 256 words, the remaining source words and the remaining destination words. All reads of a chunk come before its writes, and the words are written to the destination in read order. The command completes when either remaining length is zero.
- R6: Completing a command sets status bits 13 and 12 and removes the command from the queue. A command that has nothing to move completes without any memory access.
- R7: The queue holds 4 commands in FIFO order, and the command being executed still counts as one of them. Queue status bit 31 is set when the queue is full and bit 30 when it is empty.
- R8: An enqueue while the queue is full is dropped and sets status bit 14.
- R9: irq is the OR of all status bits whose mask bit is 0. Writing to index 4 clears the status bits written as 1 and leaves the others unchanged.
- R10: A memory request keeps its address, direction and write data unchanged until it is acknowledged. Each acknowledge moves one word.
- R11: Loopback is bit 4 of the mode register (index 7), readable and writable. The other bits of that register read as zero. The bit is sampled at the start of each chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from the index) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid together with mem_ack |
| mem_ack | input | 1 | Completes the current access |
| irq | output | 1 | Masked interrupt |

## Verification
A register write takes effect at the first rising edge after the strobe, and read data follows the index in the same cycle. Queue status therefore changes one edge after a write to index 3. A status flag and irq appear one edge after the completing or overflowing event. The bench drives its strobes between edges and reads back only after the following falling edge, which puts every sample at least one edge after the stimulus that caused it. Transfers take many cycles and the acknowledge latency varies, so the bench waits for the empty flag before it checks counts, ordering, chunk boundaries and memory contents.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 27;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RI_SRC  = 3'd0;
  localparam logic [REG_AW-1:0] RI_DST  = 3'd1;
  localparam logic [REG_AW-1:0] RI_SLEN = 3'd2;
  localparam logic [REG_AW-1:0] RI_DLEN = 3'd3;
  localparam logic [REG_AW-1:0] RI_STAT = 3'd4;
  localparam logic [REG_AW-1:0] RI_MASK = 3'd5;
  localparam logic [REG_AW-1:0] RI_QST  = 3'd6;
  localparam logic [REG_AW-1:0] RI_MODE = 3'd7;

  localparam int unsigned B_PDONE  = 12;
  localparam int unsigned B_DONE   = 13;
  localparam int unsigned B_QOVF   = 14;
  localparam int unsigned B_QEMPTY = 30;
  localparam int unsigned B_QFULL  = 31;
  localparam int unsigned B_LPBK   = 4;

  localparam logic [DATA_W-1:0] STAT_RST = 32'h8802_0000;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  slen;
    logic [LEN_W-1:0]  dlen;
  } cmd_t;
endpackage

// File: rtl/dmae_rst_sync.sv
module dmae_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dmae_regs.sv
module dmae_regs
  import dmae_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              q_full,
  input  logic              q_empty,
  input  logic              done_evt,
  output logic              push_req,
  output cmd_t              push_cmd,
  output logic              loopback,
  output logic              irq
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  slen_q, dlen_q;
  logic [DATA_W-1:0] stat_q, stat_d, mask_q;
  logic              lb_q;
  logic              src_en, dst_en, slen_en, dlen_en, mask_en, mode_en, stat_wr;
  logic              ovf_evt;

  // write decode
  always_comb begin
    src_en  = reg_we && (reg_addr == RI_SRC);
    dst_en  = reg_we && (reg_addr == RI_DST);
    slen_en = reg_we && (reg_addr == RI_SLEN);
    dlen_en = reg_we && (reg_addr == RI_DLEN);
    mask_en = reg_we && (reg_addr == RI_MASK);
    mode_en = reg_we && (reg_addr == RI_MODE);
    stat_wr = reg_we && (reg_addr == RI_STAT);
  end

  // command capture: the length write itself triggers the enqueue
  always_comb begin
    push_req      = dlen_en;
    push_cmd.src  = {src_q[ADDR_W-1:2], 2'b00};
    push_cmd.dst  = {dst_q[ADDR_W-1:2], 2'b00};
    push_cmd.slen = slen_q;
    push_cmd.dlen = reg_wdata[LEN_W-1:0];
    ovf_evt       = dlen_en && q_full;
  end

  // status next state: hardware set wins over software clear
  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_q & ~reg_wdata;
    if (done_evt) begin
      stat_d[B_DONE]  = 1'b1;
      stat_d[B_PDONE] = 1'b1;
    end
    if (ovf_evt) stat_d[B_QOVF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      slen_q <= '0;
      dlen_q <= '0;
      mask_q <= '1;
      lb_q   <= 1'b0;
      stat_q <= STAT_RST;
    end else begin
      if (src_en)  src_q  <= reg_wdata;
      if (dst_en)  dst_q  <= reg_wdata;
      if (slen_en) slen_q <= reg_wdata[LEN_W-1:0];
      if (dlen_en) dlen_q <= reg_wdata[LEN_W-1:0];
      if (mask_en) mask_q <= reg_wdata;
      if (mode_en) lb_q   <= reg_wdata[B_LPBK];
      stat_q <= stat_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_SRC:  reg_rdata = src_q;
      RI_DST:  reg_rdata = dst_q;
      RI_SLEN: reg_rdata = {{(DATA_W-LEN_W){1'b0}}, slen_q};
      RI_DLEN: reg_rdata = {{(DATA_W-LEN_W){1'b0}}, dlen_q};
      RI_STAT: reg_rdata = stat_q;
      RI_MASK: reg_rdata = mask_q;
      RI_QST: begin
        reg_rdata[B_QFULL]  = q_full;
        reg_rdata[B_QEMPTY] = q_empty;
      end
      RI_MODE: reg_rdata[B_LPBK] = lb_q;
      default: reg_rdata = '0;
    endcase
  end

  assign loopback = lb_q;
  assign irq      = |(stat_q & ~mask_q);

  assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (stat_q[B_DONE] && stat_q[B_PDONE]));
  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && q_full) |=> stat_q[B_QOVF]);
  assert_full_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
endmodule

// File: rtl/dmae_cmd_fifo.sv
module dmae_cmd_fifo
  import dmae_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t push_cmd,
  input  logic pop,
  output cmd_t head,
  output logic full,
  output logic empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;
  cmd_t          ent_q [DEPTH];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    empty  = (cnt_q == '0);
    wr_en  = push && !full;
    rd_en  = pop && !empty;
    wptr_d = wr_en ? ptr_next(wptr_q) : wptr_q;
    rptr_d = rd_en ? ptr_next(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (wr_en && !rd_en)      cnt_d = cnt_q + CW'(1);
    else if (rd_en && !wr_en) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ent_q[i] <= '0;
      else if (wr_en && (wptr_q == PW'(i)))   ent_q[i] <= push_cmd;
    end
  end

  assign head = ent_q[rptr_q];

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(cnt_q) && $stable(wptr_q)));
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/dmae_mover.sv
module dmae_mover
  import dmae_pkg::*;
#(
  parameter int unsigned CHUNK_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              head,
  input  logic              q_empty,
  input  logic              loopback,
  output logic              pop,
  output logic              done_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int unsigned CW = $clog2(CHUNK_WORDS + 1);
  localparam int unsigned IW = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_RD, S_WR} st_e;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [LEN_W-1:0]  rems_q, rems_d, remd_q, remd_d;
  logic              lb_q, lb_d;
  logic [CW-1:0]     cnt_q, cnt_d, n_q, n_d;
  logic [LEN_W-1:0]  chunk;
  logic              last_word;
  logic              buf_we;
  logic [DATA_W-1:0] buf_q [CHUNK_WORDS];

  // size of the next chunk from the remaining lengths
  always_comb begin
    chunk = (rems_q < LEN_W'(CHUNK_WORDS)) ? rems_q : LEN_W'(CHUNK_WORDS);
    if (loopback && (remd_q < chunk)) chunk = remd_q;
    last_word = (cnt_q == (n_q - CW'(1)));
  end

  always_comb begin
    st_d      = st_q;
    src_d     = src_q;
    dst_d     = dst_q;
    rems_d    = rems_q;
    remd_d    = remd_q;
    lb_d      = lb_q;
    cnt_d     = cnt_q;
    n_d       = n_q;
    pop       = 1'b0;
    done_evt  = 1'b0;
    buf_we    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = src_q;
    mem_wdata = buf_q[cnt_q[IW-1:0]];
    case (st_q)
      S_IDLE: begin
        if (!q_empty) begin
          src_d  = head.src;
          dst_d  = head.dst;
          rems_d = head.slen;
          remd_d = head.dlen;
          st_d   = S_PLAN;
        end
      end
      S_PLAN: begin
        lb_d  = loopback;
        cnt_d = '0;
        if (chunk == '0) begin
          pop      = 1'b1;
          done_evt = 1'b1;
          st_d     = S_IDLE;
        end else begin
          n_d  = chunk[CW-1:0];
          st_d = S_RD;
        end
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q;
        if (mem_ack) begin
          buf_we = lb_q;
          src_d  = src_q + ADDR_W'(4);
          rems_d = rems_q - LEN_W'(1);
          if (last_word) begin
            cnt_d = '0;
            st_d  = lb_q ? S_WR : S_PLAN;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      S_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_ack) begin
          dst_d  = dst_q + ADDR_W'(4);
          remd_d = remd_q - LEN_W'(1);
          if (last_word) begin
            cnt_d = '0;
            st_d  = S_PLAN;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      rems_q <= '0;
      remd_q <= '0;
      lb_q   <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      rems_q <= rems_d;
      remd_q <= remd_d;
      lb_q   <= lb_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
    end
  end

  // chunk buffer: data only, no reset
  for (genvar i = 0; i < CHUNK_WORDS; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (buf_we && (cnt_q == CW'(i))) buf_q[i] <= mem_rdata;
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  assert_write_needs_loopback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> lb_q);
  assert_chunk_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD) |-> ((n_q != '0) && (n_q <= CW'(CHUNK_WORDS))));
endmodule

// File: rtl/dma_cmd_engine.sv
module dma_cmd_engine
  import dmae_pkg::*;
#(
  parameter int unsigned QDEPTH      = 4,
  parameter int unsigned CHUNK_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              irq
);
  logic rst_n_s;
  logic q_full, q_empty, pop, done_evt, push_req, loopback;
  cmd_t push_cmd, head;

  dmae_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dmae_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .done_evt  (done_evt),
    .push_req  (push_req),
    .push_cmd  (push_cmd),
    .loopback  (loopback),
    .irq       (irq)
  );

  dmae_cmd_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (push_req),
    .push_cmd (push_cmd),
    .pop      (pop),
    .head     (head),
    .full     (q_full),
    .empty    (q_empty)
  );

  dmae_mover #(.CHUNK_WORDS(CHUNK_WORDS)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .head      (head),
    .q_empty   (q_empty),
    .loopback  (loopback),
    .pop       (pop),
    .done_evt  (done_evt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );
endmodule

// File: tb/sim_dma_cmd_engine.sv
`timescale 1ns/1ps
module sim_dma_cmd_engine;
  localparam logic [2:0] X_SRC = 3'd0, X_DST = 3'd1, X_SLEN = 3'd2, X_DLEN = 3'd3;
  localparam logic [2:0] X_STAT = 3'd4, X_MASK = 3'd5, X_QST = 3'd6, X_MODE = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  always #10 clk = ~clk;

  dma_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  int lat = 0, lat_cnt = 0;
  int n_rd, n_wr, nseg, nst, hold_viol;
  logic seg0_we;
  int seg_len [16];
  logic [31:0] st_addr [8];
  logic [31:0] first_rd, last_rd, prev_wait_addr;
  logic prev_wait;
  logic [31:0] mem [2048];
  logic [31:0] v;

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 | i;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clr_log();
    n_rd = 0; n_wr = 0; nseg = 0; nst = 0; seg0_we = 1'b0;
    for (int i = 0; i < 16; i++) seg_len[i] = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int k = 0;
    do begin
      rd(X_QST, s);
      k++;
    end while (!s[30] && k < 60000);
    if (!s[30]) chk("R7 queue drained", s, 32'h4000_0000);
    repeat (3) @(negedge clk);
  endtask

  // memory responder: acknowledges after lat waiting cycles, one word per ack
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; prev_wait = 1'b0; prev_wait_addr = '0; hold_viol = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        prev_wait = 1'b0;
      end else if (mem_req) begin
        if (prev_wait && mem_addr !== prev_wait_addr) hold_viol++;
        prev_wait = 1'b1; prev_wait_addr = mem_addr;
        if (lat_cnt >= lat) begin
          lat_cnt = 0;
          mem_ack = 1'b1;
          prev_wait = 1'b0;
          if (nseg == 0 || mem_we != (nseg[0] ? seg0_we : !seg0_we)) begin
            if (nseg == 0) seg0_we = mem_we;
            nseg++;
          end
          if (nseg <= 16) seg_len[nseg-1]++;
          if (mem_we) begin
            mem[mem_addr[12:2]] = mem_wdata;
            n_wr++;
          end else begin
            mem_rdata = mem[mem_addr[12:2]];
            if (n_rd == 0 || mem_addr != last_rd + 32'd4) begin
              if (nst < 8) st_addr[nst] = mem_addr;
              nst++;
            end
            if (n_rd == 0) first_rd = mem_addr;
            last_rd = mem_addr;
            n_rd++;
          end
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    clr_log();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(X_STAT, v); chk("R1 status reset", v, 32'h8802_0000);
    rd(X_MASK, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
    rd(X_QST, v);  chk("R1 queue status reset", v, 32'h4000_0000);
    rd(X_MODE, v); chk("R1 mode reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R3 length width, R11 mode bit
    wr(X_SLEN, 32'hFFFF_FFFF); rd(X_SLEN, v); chk("R3 length keeps 27 bits", v, 32'h07FF_FFFF);
    wr(X_MODE, 32'hFFFF_FFFF); rd(X_MODE, v); chk("R11 loopback bit only", v, 32'h0000_0010);
    wr(X_MODE, 32'h0);         rd(X_MODE, v); chk("R11 loopback cleared", v, 32'h0);

    // R4 / R2 source-only consumption, unaligned source, nonzero dest length
    wr(X_STAT, 32'hFFFF_FFFF);
    clr_log(); lat = 0;
    wr(X_SRC, 32'h0000_0103); wr(X_DST, 32'h0000_1000); wr(X_SLEN, 32'd10); wr(X_DLEN, 32'd7);
    wait_idle();
    chk("R4 read count", n_rd, 10);
    chk("R4 no writes", n_wr, 0);
    chk("R2 source aligned", first_rd, 32'h0000_0100);
    chk("R4 sequential last address", last_rd, 32'h0000_0124);
    rd(X_STAT, v); chk("R6 done flags", v, 32'h0000_3000);
    chk("R9 masked irq low", {31'b0, irq}, 32'h0);
    chk("R4 destination untouched", mem[1024], pat(1024));

    // R9 write-1-to-clear and mask
    wr(X_STAT, 32'h0000_1000); rd(X_STAT, v); chk("R9 w1c clears one bit", v, 32'h0000_2000);
    wr(X_STAT, 32'h0);         rd(X_STAT, v); chk("R9 zero write keeps", v, 32'h0000_2000);
    wr(X_MASK, ~32'h0000_2000); rd(X_MASK, v);
    chk("R9 irq on unmasked bit", {31'b0, irq}, 32'h1);
    wr(X_STAT, 32'h0000_2000);  rd(X_STAT, v);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(X_MASK, 32'hFFFF_FFFF);

    // R5 loopback, 300 words, chunk of 256 then 44
    clr_log(); lat = 1;
    wr(X_MODE, 32'h10);
    wr(X_SRC, 32'h0); wr(X_DST, 32'h0000_1002); wr(X_SLEN, 32'd300); wr(X_DLEN, 32'd300);
    wait_idle();
    chk("R5 segment count", nseg, 4);
    chk("R5 chunk starts with reads", {31'b0, seg0_we}, 32'h0);
    chk("R5 first read chunk", seg_len[0], 256);
    chk("R5 first write chunk", seg_len[1], 256);
    chk("R5 second read chunk", seg_len[2], 44);
    chk("R5 second write chunk", seg_len[3], 44);
    bad = 0;
    for (int i = 0; i < 300; i++) if (mem[1024 + i] !== pat(i)) bad++;
    chk("R5 copied data (R2 aligned dest)", bad, 0);
    rd(X_STAT, v); chk("R6 done after copy", v & 32'h0000_3000, 32'h0000_3000);

    // R5 destination shorter than source
    wr(X_STAT, 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) mem[1536 + i] = 32'h0;
    clr_log(); lat = 2;
    wr(X_SRC, 32'h0000_0200); wr(X_DST, 32'h0000_1800); wr(X_SLEN, 32'd20); wr(X_DLEN, 32'd5);
    wait_idle();
    chk("R5 short dest reads", n_rd, 5);
    chk("R5 short dest writes", n_wr, 5);
    bad = 0;
    for (int i = 0; i < 5; i++) if (mem[1536 + i] !== pat(128 + i)) bad++;
    chk("R5 short dest data", bad, 0);
    chk("R5 beyond dest untouched", mem[1541], 32'h0);
    rd(X_STAT, v); chk("R6 done short dest", v, 32'h0000_3000);

    // R6 empty commands
    wr(X_STAT, 32'hFFFF_FFFF); clr_log();
    wr(X_MODE, 32'h0); wr(X_SLEN, 32'd0); wr(X_DLEN, 32'd0);
    wait_idle();
    chk("R6 zero source no access", n_rd + n_wr, 0);
    rd(X_STAT, v); chk("R6 zero source done", v, 32'h0000_3000);
    wr(X_STAT, 32'hFFFF_FFFF); clr_log();
    wr(X_MODE, 32'h10); wr(X_SLEN, 32'd8); wr(X_DLEN, 32'd0);
    wait_idle();
    chk("R6 loopback zero dest no access", n_rd + n_wr, 0);
    rd(X_STAT, v); chk("R6 loopback zero dest done", v, 32'h0000_3000);

    // R7 / R8 queue order, full flag and overflow
    wr(X_STAT, 32'hFFFF_FFFF); clr_log(); lat = 3;
    wr(X_MODE, 32'h0);
    wr(X_SRC, 32'h0);         wr(X_SLEN, 32'd2000); wr(X_DLEN, 32'd1);
    wr(X_SRC, 32'h0000_1000); wr(X_SLEN, 32'd4);    wr(X_DLEN, 32'd1);
    wr(X_SRC, 32'h0000_1400); wr(X_SLEN, 32'd4);    wr(X_DLEN, 32'd1);
    wr(X_SRC, 32'h0000_1800); wr(X_SLEN, 32'd4);    wr(X_DLEN, 32'd1);
    rd(X_QST, v); chk("R7 full flag", v, 32'h8000_0000);
    rd(X_STAT, v); chk("R8 no overflow yet", v, 32'h0);
    wr(X_SRC, 32'h0000_1C00); wr(X_SLEN, 32'd100); wr(X_DLEN, 32'd1);
    rd(X_STAT, v); chk("R8 overflow flag", v, 32'h0000_4000);
    wr(X_MASK, ~32'h0000_4000); rd(X_MASK, v);
    chk("R9 irq on overflow", {31'b0, irq}, 32'h1);
    wr(X_MASK, 32'hFFFF_FFFF);
    wait_idle();
    chk("R8 dropped command not run", n_rd, 2012);
    chk("R7 command count", nst, 4);
    chk("R7 order first", st_addr[0], 32'h0);
    chk("R7 order second", st_addr[1], 32'h0000_1000);
    chk("R7 order third", st_addr[2], 32'h0000_1400);
    chk("R7 order fourth", st_addr[3], 32'h0000_1800);
    rd(X_QST, v); chk("R7 empty at end", v, 32'h4000_0000);
    chk("R10 request held until ack", hold_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule